// File: doc/BRIEF.md
# Warp Load Segment Coalescer

This block accepts one load request for a group of 32 lanes and turns it into the smallest set of aligned memory segment requests. Each lane supplies a byte address, an access length of 1 to 16 bytes and an active bit. The segment granule is 32 bytes or 128 bytes, chosen by `seg_big`. A lane whose address shares no segment with any other lane still costs one whole segment, even when it reads a single byte.

Segments leave on a valid/ready interface, one per cycle. Each segment carries a 32-bit lane mask that names the lanes it serves, so that returned data can later be steered to those lanes. When the last segment has been taken, the block pulses `done` and becomes idle again. It accepts a new request only while idle.

The controller has three states. `ST_IDLE` raises `req_ready` and, on `req_valid`, moves to `ST_EMIT` (transition *accept*). In that transition it captures each lane's first and last segment and marks them pending. `ST_EMIT` presents the earliest pending segment. It stays in `ST_EMIT` while more segments remain after a handshake (transition *next*). It moves to `ST_FINISH` when the final segment is taken, or when nothing was pending (transition *drain*). `ST_FINISH` drives `done` for one cycle and returns to `ST_IDLE` (transition *release*).

Top module: `warp_coalescer`

## Requirements
- R1: `seg_addr` is a lane byte address with its low 5 bits cleared when `seg_big`=0 (32-byte segments), or its low 7 bits cleared when `seg_big`=1 (128-byte segments). `seg_big` is sampled when the request is accepted.
- R2: Within one warp request, each distinct segment that active lanes touch is emitted exactly once, and no other segment is emitted.
- R3: A lane with its `req_mask` bit clear causes no segment and never appears in `seg_lanes`.
- R4: Bit i of `seg_lanes` is set exactly when lane i is active and its byte range touches the emitted segment. The union of all masks of one request equals `req_mask`.
- R5: Segments are emitted in first-reference order. Lanes are scanned from lane 0 upward, and within a lane its lower segment comes before its upper segment.
- R6: Lane i reads bytes `addr` to `addr+n`. If that range crosses a segment boundary, both segments are requested and lane i is set in both masks.
- R7: Lane i's address is `req_addr[32i+31:32i]`. Its length field is `req_size[4i+3:4i]`, where value n means n+1 bytes.
- R8: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr` and `seg_lanes` hold.
- R9: `done` is high for exactly one cycle: the cycle after the last segment is accepted. With no active lane, no segment is emitted and `done` still pulses once.
- R10: `req_ready` is high only in the idle state. No request is taken from acceptance until after `done`.
- R11: Thirty-two active lanes reading contiguous, aligned 4-byte words produce four segments with 32-byte granules and one segment with 128-byte granules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_mask | input | 32 | Active lane bits |
| req_addr | input | 1024 | Per-lane byte addresses, 32 bits each |
| req_size | input | 128 | Per-lane length minus one, 4 bits each |
| seg_big | input | 1 | 0: 32-byte segments, 1: 128-byte segments |
| seg_valid | output | 1 | Segment request present |
| seg_ready | input | 1 | Downstream takes the segment |
| seg_addr | output | 32 | Aligned segment base address |
| seg_lanes | output | 32 | Lanes served by this segment |
| done | output | 1 | Warp request fully emitted |

## Verification
Two things can fall in the same cycle: a segment is accepted, and pending entries held by later lanes are retired because they name that same segment. Whether the warp is then finished is also decided in that cycle. Random warps confined to a narrow address window, with random `seg_ready` back-pressure, make later lanes share segments with earlier ones, including segments reached only through a boundary-crossing upper half. Every emitted address and mask is compared in order against a list built by a bench model, and the segment count is compared when `done` rises. A segment that is emitted twice, or a `done` that comes early, therefore shows up as a mismatch.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EMIT,
        ST_FINISH
    } coal_state_e;

    localparam int SMALL_OFF = 5;   // 32-byte granule
    localparam int LARGE_OFF = 7;   // 128-byte granule
endpackage

// File: rtl/seg_calc.sv
module seg_calc #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] len_m1,
    input  logic              big,
    output logic [ADDR_W-1:0] lo_seg,
    output logic [ADDR_W-1:0] hi_seg
);
    import coal_pkg::*;

    logic [ADDR_W-1:0] keep;
    logic [ADDR_W-1:0] last_byte;

    always_comb begin
        keep      = big ? ~((ADDR_W'(1) << LARGE_OFF) - ADDR_W'(1))
                        : ~((ADDR_W'(1) << SMALL_OFF) - ADDR_W'(1));
        last_byte = addr + ADDR_W'(len_m1);
        lo_seg    = addr & keep;
        hi_seg    = last_byte & keep;
    end
endmodule

// File: rtl/first_pick.sv
module first_pick #(
    parameter int N = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) idx = IDX_W'(k);
        end
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 4,
    localparam int ENTRIES = 2 * LANES,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [LANES-1:0]         req_mask,
    input  logic [LANES*ADDR_W-1:0]  req_addr,
    input  logic [LANES*SIZE_W-1:0]  req_size,
    input  logic                     seg_big,
    output logic                     seg_valid,
    input  logic                     seg_ready,
    output logic [ADDR_W-1:0]        seg_addr,
    output logic [LANES-1:0]         seg_lanes,
    output logic                     done
);
    import coal_pkg::*;

    coal_state_e state_q, state_d;

    logic [ADDR_W-1:0] lo_new [LANES];
    logic [ADDR_W-1:0] hi_new [LANES];
    logic [ADDR_W-1:0] lo_q   [LANES];
    logic [ADDR_W-1:0] hi_q   [LANES];
    logic [LANES-1:0]  pend_lo_q, pend_hi_q;
    logic [LANES-1:0]  act_q;
    logic              big_q;

    logic [ENTRIES-1:0] pend_vec;
    logic [LANES-1:0]   eq_lo, eq_hi;
    logic [LANES-1:0]   left_lo, left_hi;
    logic               found;
    logic [IDX_W-1:0]   pick;
    logic [ADDR_W-1:0]  cur_seg;
    logic               take;
    logic               last_take;

    // per-lane segment bounds and the interleaved pending vector
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        seg_calc #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_calc (
            .addr   (req_addr[g*ADDR_W +: ADDR_W]),
            .len_m1 (req_size[g*SIZE_W +: SIZE_W]),
            .big    (seg_big),
            .lo_seg (lo_new[g]),
            .hi_seg (hi_new[g])
        );
        assign pend_vec[2*g]   = pend_lo_q[g];
        assign pend_vec[2*g+1] = pend_hi_q[g];
        assign eq_lo[g] = (lo_q[g] == cur_seg);
        assign eq_hi[g] = (hi_q[g] == cur_seg);
    end

    first_pick #(.N(ENTRIES)) u_pick (
        .req   (pend_vec),
        .found (found),
        .idx   (pick)
    );

    always_comb begin
        cur_seg   = pick[0] ? hi_q[pick[IDX_W-1:1]] : lo_q[pick[IDX_W-1:1]];
        left_lo   = pend_lo_q & ~eq_lo;
        left_hi   = pend_hi_q & ~eq_hi;
        take      = (state_q == ST_EMIT) && found && seg_ready;
        last_take = take && (left_lo == '0) && (left_hi == '0);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_EMIT;
            ST_EMIT:   if (!found || last_take) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pend_lo_q <= '0;
            pend_hi_q <= '0;
            act_q     <= '0;
            big_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                act_q <= req_mask;
                big_q <= seg_big;
                for (int i = 0; i < LANES; i++) begin
                    lo_q[i]      <= lo_new[i];
                    hi_q[i]      <= hi_new[i];
                    pend_lo_q[i] <= req_mask[i];
                    pend_hi_q[i] <= req_mask[i] && (hi_new[i] != lo_new[i]);
                end
            end else if (take) begin
                pend_lo_q <= left_lo;
                pend_hi_q <= left_hi;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        seg_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_EMIT:   seg_valid = found;
            ST_FINISH: done      = 1'b1;
            default:   ;
        endcase
        seg_addr  = cur_seg;
        seg_lanes = act_q & (eq_lo | eq_hi);
    end

    // ---------------- assertions ----------------
    logic [LANES-1:0] union_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                           union_q <= '0;
        else if (state_q == ST_IDLE && req_valid) union_q <= '0;
        else if (seg_valid && seg_ready)      union_q <= union_q | seg_lanes;
    end

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_lanes));

    a_r3_lanes_active: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_lanes != '0) && ((seg_lanes & ~act_q) == '0));

    a_r4_union: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> union_q == act_q);

    a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (big_q ? (seg_addr[LARGE_OFF-1:0] == '0)
                             : (seg_addr[SMALL_OFF-1:0] == '0)));

    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
endmodule

// File: tb/warp_coalescer_test.sv
module warp_coalescer_test;
    localparam int L = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [L-1:0]   req_mask = '0;
    logic [L*32-1:0] req_addr = '0;
    logic [L*4-1:0] req_size = '0;
    logic           seg_big = 1'b0;
    logic           seg_valid;
    logic           seg_ready = 1'b0;
    logic [31:0]    seg_addr;
    logic [L-1:0]   seg_lanes;
    logic           done;

    int tests = 0;
    int fails = 0;
    bit timed_out = 0;

    logic [31:0]  exp_addr [64];
    logic [L-1:0] exp_mask [64];
    int           exp_n;

    warp_coalescer uut (.*);

    always #2 clk = ~clk;   // 250 MHz

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // bench model: list distinct segments in first-reference order, then lane masks
    task automatic build_expect();
        logic [31:0] km, lo, hi, s;
        logic [31:0] los [L];
        logic [31:0] his [L];
        bit seen;
        km = seg_big ? ~32'd127 : ~32'd31;
        exp_n = 0;
        for (int i = 0; i < L; i++) begin
            lo = req_addr[i*32 +: 32] & km;
            hi = (req_addr[i*32 +: 32] + 32'(req_size[i*4 +: 4])) & km;
            los[i] = lo;
            his[i] = hi;
            if (req_mask[i]) begin
                for (int p = 0; p < 2; p++) begin
                    s = (p == 0) ? lo : hi;
                    seen = 0;
                    for (int e = 0; e < exp_n; e++) if (exp_addr[e] == s) seen = 1;
                    if (!seen) begin
                        exp_addr[exp_n] = s;
                        exp_n++;
                    end
                end
            end
        end
        for (int e = 0; e < exp_n; e++) begin
            exp_mask[e] = '0;
            for (int i = 0; i < L; i++)
                if (req_mask[i] && (los[i] == exp_addr[e] || his[i] == exp_addr[e]))
                    exp_mask[e][i] = 1'b1;
        end
    endtask

    task automatic run_warp(input string tag, input int ready_pct);
        int got;
        int waitc;
        build_expect();
        @(negedge clk);
        check(req_ready === 1'b1, "R10", {tag, " idle ready"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready === 1'b0, "R10", {tag, " busy"}, 64'(req_ready), 64'd0);
        got = 0;
        waitc = 0;
        forever begin
            if (done) break;
            seg_ready = ($urandom_range(99) < ready_pct);
            #1;
            if (seg_valid && seg_ready) begin
                if (got < exp_n) begin
                    check(seg_addr == exp_addr[got], "R1/R2/R5", {tag, " addr"},
                          64'(seg_addr), 64'(exp_addr[got]));
                    check(seg_lanes == exp_mask[got], "R4/R6", {tag, " lanes"},
                          64'(seg_lanes), 64'(exp_mask[got]));
                end
                got++;
            end
            @(negedge clk);
            waitc++;
            if (waitc > 2000) begin
                check(0, "R9", {tag, " stuck"}, 64'(got), 64'(exp_n));
                break;
            end
        end
        seg_ready = 1'b0;
        check(got == exp_n, "R2", {tag, " count"}, 64'(got), 64'(exp_n));
        @(negedge clk);
        check(done === 1'b0, "R9", {tag, " single pulse"}, 64'(done), 64'd0);
    endtask

    function automatic logic [31:0] rnd_addr(input logic [31:0] base, input int span);
        return base + 32'($urandom_range(span - 1));
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        timed_out = 1;
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && seg_valid === 1'b0 && done === 1'b0,
              "R10", "reset state", {61'd0, req_ready, seg_valid, done}, 64'b100);

        // R11 / R7: contiguous 4-byte words, 32-byte then 128-byte granule
        for (int i = 0; i < L; i++) begin
            req_addr[i*32 +: 32] = 32'h1000 + 32'(4 * i);
            req_size[i*4 +: 4]   = 4'd3;
        end
        req_mask = '1;
        seg_big  = 1'b0;
        run_warp("R11 small", 100);
        check(exp_n == 4, "R11", "small granule count", 64'(exp_n), 64'd4);
        seg_big = 1'b1;
        run_warp("R11 big", 60);
        check(exp_n == 1, "R11", "big granule count", 64'(exp_n), 64'd1);

        // R9 / R3: no active lane
        req_mask = '0;
        run_warp("R9 empty", 100);

        // R3: inactive lanes point at unique segments
        seg_big = 1'b0;
        for (int i = 0; i < L; i++) req_addr[i*32 +: 32] = 32'h8000 + 32'(64 * i);
        req_mask = 32'h0000_0005;
        run_warp("R3 sparse", 100);

        // R6: lane 0 crosses, lane 1 lone 1-byte in upper segment
        req_mask = 32'h3;
        req_addr[0 +: 32]  = 32'h201C;
        req_size[0 +: 4]   = 4'd15;
        req_addr[32 +: 32] = 32'h2025;
        req_size[4 +: 4]   = 4'd0;
        run_warp("R6 cross", 100);
        check(exp_n == 2, "R6", "cross count", 64'(exp_n), 64'd2);

        // R5: later lanes reference earlier segments; lone scattered lane
        req_mask = 32'hF;
        req_addr[0  +: 32] = 32'h3040; req_size[0  +: 4] = 4'd3;
        req_addr[32 +: 32] = 32'h9000; req_size[4  +: 4] = 4'd0;
        req_addr[64 +: 32] = 32'h3044; req_size[8  +: 4] = 4'd7;
        req_addr[96 +: 32] = 32'h9010; req_size[12 +: 4] = 4'd15;
        run_warp("R5 order", 50);

        // random warps with back-pressure (R8 hold via stalls)
        for (int t = 0; t < 60; t++) begin
            seg_big  = 1'($urandom_range(1));
            req_mask = $urandom();
            for (int i = 0; i < L; i++) begin
                req_addr[i*32 +: 32] = rnd_addr(32'h4000, (t % 3 == 0) ? 4096 : 384);
                req_size[i*4 +: 4]   = 4'($urandom_range(15));
            end
            run_warp("rand", 30 + 10 * (t % 7));
        end

        if (!timed_out) begin
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule